// File: doc/BRIEF.md
# Encoded Ratio Clock Divider

This block divides a fast reference into three clock enables. Each enable is a single-cycle pulse that fires once every N counted reference ticks. N comes from a divider code held in one of two 32-bit selection words. Each code field maps to a ratio through its own rule.

Output 0 can count ticks from either a primary or an alternate reference. Outputs 1 and 2 always count primary ticks. Both references enter as tick qualifiers synchronous to `clk`.

Software writes a selection word through a simple write port. Every output reports the ratio it is currently running, and output 0 also reports its active source. A changed code or source is not applied straight away: it is taken up only when the running period completes, so no shortened period is ever produced.

Top module: `clk_ratio_div`

## Requirements
- R1: During and straight after reset, `en_out` is 0, every ratio report reads 2 and `src0_o` reads 0. Both selection words reset to zero.
- R2: Output 0 ratio comes from word A bits 30:28. Code 0 gives 2, and any other code n gives n+1.
- R3: Output 1 ratio comes from word A bits 11:8 and equals 2*(n+1), which is always even and lies between 2 and 32.
- R4: Output 2 ratio comes from word B bits 30:28 and follows the rule of R2. A write with `wr_sel`=0 loads word A, and `wr_sel`=1 loads word B.
- R5: Word A bit 31 picks the ticks that output 0 counts: 0 selects `pri_tick` and 1 selects `alt_tick`. Outputs 1 and 2 always count `pri_tick`.
- R6: `en_out[i]` goes high for exactly one cycle, in the cycle after the tick that completes a period of the active ratio. There is exactly one pulse per ratio ticks.
- R7: A new code or source takes effect only at the tick that ends the current period. The ratio and source reports change only together with a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for a selection word |
| wr_sel | input | 1 | 0 writes word A, 1 writes word B |
| wr_data | input | 32 | Selection word value |
| pri_tick | input | 1 | Primary reference tick qualifier |
| alt_tick | input | 1 | Alternate reference tick qualifier |
| en_out | output | 3 | Divided enable pulses, one per output |
| ratio0_o | output | 6 | Active ratio of output 0 |
| ratio1_o | output | 6 | Active ratio of output 1 |
| ratio2_o | output | 6 | Active ratio of output 2 |
| src0_o | output | 1 | Active source of output 0 (1 = alternate) |

## Verification
The assertions assume that the reference ticks are one-cycle qualifiers, already synchronous to `clk`, and that the write inputs carry known values once reset is released. The bench drives every input on the falling edge of `clk`. It steps through every code of each field while primary ticks run continuously. It then runs sparse, random ticks on both references, with writes that land in the middle of a period, so that the deferred take-up and the source switch are exercised under arbitrary tick spacing.

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          pri_tick,
  input  logic          alt_tick,
  output logic [2:0]    en_out,
  output logic [RW-1:0] ratio0_o,
  output logic [RW-1:0] ratio1_o,
  output logic [RW-1:0] ratio2_o,
  output logic          src0_o
);

  logic       a_src;
  logic [2:0] a_code0;
  logic [3:0] a_code1;
  logic [2:0] b_code2;
  logic       unused_bits;

  assign unused_bits = ^{wr_data[27:12], wr_data[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_src   <= 1'b0;
      a_code0 <= '0;
      a_code1 <= '0;
      b_code2 <= '0;
    end else if (wr_en) begin
      if (wr_sel) begin
        b_code2 <= wr_data[30:28];
      end else begin
        a_src   <= wr_data[31];
        a_code0 <= wr_data[30:28];
        a_code1 <= wr_data[11:8];
      end
    end
  end

  function automatic logic [RW-1:0] alias_ratio(input logic [2:0] c);
    return (c == 3'd0) ? RW'(2) : RW'(c) + RW'(1);
  endfunction

  logic [RW-1:0] want [3];
  logic [2:0]    tick;
  logic [2:0]    term;
  logic          src_q;

  assign want[0] = alias_ratio(a_code0);
  assign want[1] = (RW'(a_code1) + RW'(1)) << 1;
  assign want[2] = alias_ratio(b_code2);

  assign tick[0] = src_q ? alt_tick : pri_tick;
  assign tick[1] = pri_tick;
  assign tick[2] = pri_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)       src_q <= 1'b0;
    else if (term[0]) src_q <= a_src;
  end

  for (genvar i = 0; i < 3; i++) begin : g_ch
    logic [RW-1:0] cnt;
    logic [RW-1:0] act;
    logic          pulse;

    assign term[i]   = tick[i] && (cnt == act - RW'(1));
    assign en_out[i] = pulse;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt   <= '0;
        act   <= RW'(2);
        pulse <= 1'b0;
      end else begin
        pulse <= term[i];
        if (term[i]) begin
          cnt <= '0;
          act <= want[i];
        end else if (tick[i]) begin
          cnt <= cnt + RW'(1);
        end
      end
    end
  end

  assign ratio0_o = g_ch[0].act;
  assign ratio1_o = g_ch[1].act;
  assign ratio2_o = g_ch[2].act;
  assign src0_o   = src_q;

endmodule

module clk_ratio_div_chk #(
  parameter int RW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pri_tick,
  input logic          alt_tick,
  input logic [2:0]    en_out,
  input logic [RW-1:0] ratio0_o,
  input logic [RW-1:0] ratio1_o,
  input logic [RW-1:0] ratio2_o,
  input logic          src0_o
);
  AST_RATIO0_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ratio0_o >= RW'(2) && ratio0_o <= RW'(8)); // R2
  AST_RATIO1_EVEN: assert property (@(posedge clk) disable iff (!rst_n) !ratio1_o[0] && ratio1_o >= RW'(2) && ratio1_o <= RW'(32)); // R3
  AST_RATIO2_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ratio2_o >= RW'(2) && ratio2_o <= RW'(8)); // R4
  AST_SRC_TICK: assert property (@(posedge clk) disable iff (!rst_n) en_out[0] |-> ($past(src0_o) ? $past(alt_tick) : $past(pri_tick))); // R5
  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) (en_out[1] || en_out[2]) |-> $past(pri_tick)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) en_out[1] |=> !en_out[1]); // R6
  AST_RATIO_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(ratio1_o) |-> en_out[1]); // R7
  AST_SRC_AT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(src0_o) |-> en_out[0]); // R7
endmodule

bind clk_ratio_div clk_ratio_div_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pri_tick(pri_tick), .alt_tick(alt_tick),
  .en_out(en_out), .ratio0_o(ratio0_o), .ratio1_o(ratio1_o),
  .ratio2_o(ratio2_o), .src0_o(src0_o)
);

// File: tb/clk_ratio_div_test.sv
module clk_ratio_div_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pri_tick = 1'b0, alt_tick = 1'b0;
  logic [2:0]  en_out;
  logic [5:0]  ratio0_o, ratio1_o, ratio2_o;
  logic        src0_o;

  int checks = 0, fails = 0;
  int m_cnt [3];
  int m_ratio [3];
  int m_src;
  logic [31:0] m_a, m_b;
  logic [2:0] exp_en;

  always #2 clk = ~clk;

  clk_ratio_div uut (.*);

  function automatic int dec(int i, logic [31:0] a, logic [31:0] b);
    int c;
    if (i == 1) return (int'(a[11:8]) + 1) * 2;
    c = (i == 0) ? int'(a[30:28]) : int'(b[30:28]);
    return (c == 0) ? 2 : c + 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_ratio[i] = 2; end
      m_src = 0; m_a = '0; m_b = '0; exp_en = '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        logic t;
        t = (i == 0 && m_src == 1) ? alt_tick : pri_tick;
        exp_en[i] = 1'b0;
        if (t) begin
          m_cnt[i]++;
          if (m_cnt[i] == m_ratio[i]) begin
            exp_en[i] = 1'b1;
            m_cnt[i] = 0;
            m_ratio[i] = dec(i, m_a, m_b);
            if (i == 0) m_src = int'(m_a[31]);
          end
        end
      end
      if (wr_en) begin
        if (wr_sel) m_b = wr_data; else m_a = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 en_out", int'(en_out), int'(exp_en));
      check("R2 ratio0", int'(ratio0_o), m_ratio[0]);
      check("R3 ratio1", int'(ratio1_o), m_ratio[1]);
      check("R4 ratio2", int'(ratio2_o), m_ratio[2]);
      check("R5 src0", int'(src0_o), m_src);
    end
  end

  task automatic wr(logic s, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    int r1_before;
    repeat (3) @(negedge clk);
    check("R1 en_out reset", int'(en_out), 0);
    check("R1 ratio0 reset", int'(ratio0_o), 2);
    check("R1 ratio1 reset", int'(ratio1_o), 2);
    check("R1 ratio2 reset", int'(ratio2_o), 2);
    check("R1 src reset", int'(src0_o), 0);
    rst_n = 1'b1;
    pri_tick = 1'b1;
    for (int c = 0; c < 16; c++) begin
      wr(1'b0, {1'b0, 3'(c % 8), 16'h0, 4'(c), 8'h0});
      wr(1'b1, {1'b0, 3'((c + 3) % 8), 28'h0});
      repeat (70) @(negedge clk);
    end
    // R7: mid-period write must not alter ratio1 immediately
    wr(1'b0, {1'b0, 3'd0, 16'h0, 4'd15, 8'h0});
    repeat (40) @(negedge clk);
    wr(1'b0, {1'b0, 3'd0, 16'h0, 4'd0, 8'h0});
    r1_before = int'(ratio1_o);
    @(negedge clk);
    check("R7 deferred ratio1", int'(ratio1_o), r1_before);
    repeat (40) @(negedge clk);
    check("R7 new ratio1 applied", int'(ratio1_o), 2);
    wr(1'b0, {1'b1, 3'd2, 16'h0, 4'd1, 8'h0});
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      pri_tick = ($urandom % 3) != 0;
      alt_tick = ($urandom % 2) != 0;
      wr_en = ($urandom % 97) == 0;
      wr_sel = $urandom % 2;
      wr_data = $urandom;
    end
    wr_en = 1'b0;
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule